// File: doc/BRIEF.md
# Shared Memory Port Hazard Controller

This block governs a single-ported memory that two stages of a five-stage in-order pipeline must share. The stages run fetch, decode, execute, memory, write-back. Instruction fetch needs the port to read the next instruction. The memory stage needs it for a load or a store. Each cycle the controller decides who owns the port and drives the shared address, read-enable and write-enable lines. It also keeps the program counter and the fetch-to-decode register.

When both stages want the port in the same cycle, the load or store wins. The fetch slips by one cycle: the program counter and the fetch-to-decode register keep their values, and the decode stage sees a no-op in place of a new instruction. Instructions already past decode keep advancing, and a per-stage valid tracker shows the bubble travelling toward write-back. A wide counter adds one for every cycle lost to such a collision.

Top module: `shared_port_ctrl`

## Requirements
- R1: In any cycle at most one of `grant_fetch` and `grant_data` is high. While `grant_data` is high, `port_addr` carries `ls_addr`, `port_we` equals `ls_write` and `port_re` equals its inverse. While `grant_fetch` is high, `port_addr` carries `pc` and `port_re` is 1. When neither is granted, `port_re` and `port_we` are 0.
- R2: A memory-stage access (`ls_valid`) is always granted, even when `fetch_req` is also high. `fetch_stall` is high exactly in cycles where `fetch_req` and `ls_valid` are both high.
- R3: In a cycle with `grant_fetch` high, at the next clock edge `dec_instr` takes `port_rdata`, `dec_pc` takes `pc`, and `pc` advances by 4.
- R4: In a cycle without `grant_fetch`, this includes every stalled cycle, `pc` and `dec_pc` keep their values across the next clock edge.
- R5: After a cycle without `grant_fetch`, `dec_bubble` is 1 and `dec_instr` reads as the no-op code 0x00000000. After a cycle with a granted fetch, `dec_bubble` is 0.
- R6: `stage_vld` bit 0 is decode-valid (the inverse of `dec_bubble`). Bits 1, 2 and 3 are execute, memory and write-back valid. Each clock edge, bit k+1 takes the old value of bit k, whether or not a stall occurs.
- R7: `stall_count` rises by exactly 1 at the edge closing each stalled cycle and is unchanged otherwise. Two colliding accesses in back-to-back cycles cost two stall cycles, and each access gets its own port cycle.
- R8: Reset gives `pc` = 0, `stall_count` = 0, `stage_vld` = 0 and `dec_bubble` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch wants the port this cycle |
| ls_valid | input | 1 | Memory-stage instruction is a load or store |
| ls_write | input | 1 | Memory-stage access is a store |
| ls_addr | input | 32 | Memory-stage byte address |
| ls_wdata | input | 32 | Store data |
| port_addr | output | 32 | Shared memory address |
| port_re | output | 1 | Shared memory read enable |
| port_we | output | 1 | Shared memory write enable |
| port_wdata | output | 32 | Shared memory write data |
| port_rdata | input | 32 | Shared memory read data |
| data_rdata | output | 32 | Load data returned to the memory stage |
| grant_fetch | output | 1 | Fetch owns the port |
| grant_data | output | 1 | Memory stage owns the port |
| fetch_stall | output | 1 | Fetch lost a collision this cycle |
| pc | output | 32 | Program counter |
| dec_instr | output | 32 | Instruction presented to decode (no-op on bubble) |
| dec_pc | output | 32 | Address of the held decode instruction |
| dec_bubble | output | 1 | Decode holds a no-op |
| stage_vld | output | 4 | Valid bits: decode, execute, memory, write-back |
| stall_count | output | 32 | Collision stall cycles since reset |

## Verification
The first pattern is fetch-only runs, which show the program counter stepping and instruction words arriving in decode. Directed collisions come next: one isolated, then two and three back to back. These separate "data wins and fetch slips once per access" from designs that merge accesses or let fetch win. Idle cycles, with neither requester active, distinguish a bubble caused by no fetch from one caused by a collision, because only the second may move the counter. A long random mix of loads, stores and fetch requests against a bench-owned memory then checks the port lines, the fetched words and the travelling valid bits every cycle.

// File: rtl/shared_port_pkg.sv
package shared_port_pkg;

  localparam int unsigned NUM_LATE = 3;

  function automatic logic [31:0] advance_pc(input logic [31:0] cur, input int unsigned step);
    return cur + 32'(step);
  endfunction

  function automatic logic [31:0] bump_count(input logic [31:0] cur, input logic hit);
    return hit ? cur + 32'd1 : cur;
  endfunction

endpackage

// File: rtl/shared_port_arb.sv
module shared_port_arb #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          fetch_req,
  input  logic          ls_valid,
  input  logic          ls_write,
  input  logic [AW-1:0] ls_addr,
  input  logic [DW-1:0] ls_wdata,
  input  logic [AW-1:0] pc,
  output logic          grant_fetch,
  output logic          grant_data,
  output logic          collide,
  output logic [AW-1:0] port_addr,
  output logic          port_re,
  output logic          port_we,
  output logic [DW-1:0] port_wdata
);
  always_comb begin
    grant_data  = ls_valid;
    grant_fetch = fetch_req & ~ls_valid;
    collide     = fetch_req & ls_valid;
    port_addr   = grant_data ? ls_addr : pc;
    port_we     = grant_data & ls_write;
    port_re     = grant_fetch | (grant_data & ~ls_write);
    port_wdata  = ls_wdata;
  end
endmodule

// File: rtl/shared_port_fetch.sv
module shared_port_fetch #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [DW-1:0] NOP_CODE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] hold_instr,
  output logic [AW-1:0] hold_pc,
  output logic          hold_valid,
  output logic [DW-1:0] dec_instr
);
  import shared_port_pkg::*;
  localparam int unsigned STEP = DW / 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      hold_instr <= NOP_CODE;
      hold_pc    <= RESET_PC;
      hold_valid <= 1'b0;
    end else begin
      hold_valid <= take;
      if (take) begin
        hold_instr <= word;
        hold_pc    <= pc;
        pc         <= advance_pc(pc, STEP);
      end
    end
  end

  assign dec_instr = hold_valid ? hold_instr : NOP_CODE;
endmodule

// File: rtl/shared_port_track.sv
module shared_port_track #(
  parameter int unsigned LATE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head,
  output logic [LATE-1:0] tail
);
  logic [LATE:0] chain;
  assign chain[0] = head;

  for (genvar k = 0; k < LATE; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[k+1] <= 1'b0;
      else        chain[k+1] <= chain[k];
    end
    assign tail[k] = chain[k+1];
  end
endmodule

// File: rtl/shared_port_cnt.sv
module shared_port_cnt #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (hit) count <= count + CW'(1);
  end
endmodule

// File: rtl/shared_port_ctrl.sv
module shared_port_ctrl #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic          ls_valid,
  input  logic          ls_write,
  input  logic [AW-1:0] ls_addr,
  input  logic [DW-1:0] ls_wdata,
  output logic [AW-1:0] port_addr,
  output logic          port_re,
  output logic          port_we,
  output logic [DW-1:0] port_wdata,
  input  logic [DW-1:0] port_rdata,
  output logic [DW-1:0] data_rdata,
  output logic          grant_fetch,
  output logic          grant_data,
  output logic          fetch_stall,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] dec_instr,
  output logic [AW-1:0] dec_pc,
  output logic          dec_bubble,
  output logic [3:0]    stage_vld,
  output logic [CW-1:0] stall_count
);
  import shared_port_pkg::*;

  logic          collide;
  logic          id_valid;
  logic [DW-1:0] held_word;
  logic [NUM_LATE-1:0] late_vld;

  shared_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .fetch_req  (fetch_req),
    .ls_valid   (ls_valid),
    .ls_write   (ls_write),
    .ls_addr    (ls_addr),
    .ls_wdata   (ls_wdata),
    .pc         (pc),
    .grant_fetch(grant_fetch),
    .grant_data (grant_data),
    .collide    (collide),
    .port_addr  (port_addr),
    .port_re    (port_re),
    .port_we    (port_we),
    .port_wdata (port_wdata)
  );

  shared_port_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (grant_fetch),
    .word      (port_rdata),
    .pc        (pc),
    .hold_instr(held_word),
    .hold_pc   (dec_pc),
    .hold_valid(id_valid),
    .dec_instr (dec_instr)
  );

  shared_port_track #(.LATE(NUM_LATE)) u_track (
    .clk  (clk),
    .rst_n(rst_n),
    .head (id_valid),
    .tail (late_vld)
  );

  shared_port_cnt #(.CW(CW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (collide),
    .count(stall_count)
  );

  assign fetch_stall = collide;
  assign dec_bubble  = ~id_valid;
  assign stage_vld   = {late_vld, id_valid};
  assign data_rdata  = port_rdata;
endmodule

// File: rtl/shared_port_ctrl_chk.sv
module shared_port_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_req,
  input logic        ls_valid,
  input logic        ls_write,
  input logic        grant_fetch,
  input logic        grant_data,
  input logic        port_re,
  input logic        port_we,
  input logic        fetch_stall,
  input logic [31:0] pc,
  input logic [31:0] dec_pc,
  input logic        dec_bubble,
  input logic [3:0]  stage_vld,
  input logic [31:0] stall_count
);
  a_r1_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_fetch, grant_data}) && !(port_re && port_we));

  a_r2_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    ls_valid |-> (grant_data && !grant_fetch));

  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fetch |=> (pc == $past(pc) + 32'd4) && (dec_pc == $past(pc)));

  a_r4_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_fetch |=> $stable(pc) && $stable(dec_pc));

  a_r5_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> dec_bubble);

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage_vld[3:1] == $past(stage_vld[2:0]));

  a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && ls_valid) |=> stall_count == $past(stall_count) + 32'd1);

  a_r7_count_flat: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && ls_valid) |=> $stable(stall_count));
endmodule

bind shared_port_ctrl shared_port_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_req  (fetch_req),
  .ls_valid   (ls_valid),
  .ls_write   (ls_write),
  .grant_fetch(grant_fetch),
  .grant_data (grant_data),
  .port_re    (port_re),
  .port_we    (port_we),
  .fetch_stall(fetch_stall),
  .pc         (pc),
  .dec_pc     (dec_pc),
  .dec_bubble (dec_bubble),
  .stage_vld  (stage_vld),
  .stall_count(stall_count)
);

// File: tb/shared_port_ctrl_bench.sv
module shared_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0, ls_valid = 1'b0, ls_write = 1'b0;
  logic [31:0] ls_addr = '0, ls_wdata = '0;
  logic [31:0] port_addr, port_wdata, port_rdata, data_rdata;
  logic        port_re, port_we, grant_fetch, grant_data, fetch_stall, dec_bubble;
  logic [31:0] pc, dec_instr, dec_pc, stall_count;
  logic [3:0]  stage_vld;

  logic [31:0] mem [64];
  int total = 0, bad = 0;
  bit done = 0;

  // expected model
  logic [31:0] m_pc, m_instr, m_dpc, m_cnt;
  logic        m_vld;
  logic [3:0]  m_sv;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign port_rdata = mem[port_addr[7:2]];

  shared_port_ctrl u_shared_port_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .ls_valid(ls_valid),
    .ls_write(ls_write), .ls_addr(ls_addr), .ls_wdata(ls_wdata),
    .port_addr(port_addr), .port_re(port_re), .port_we(port_we),
    .port_wdata(port_wdata), .port_rdata(port_rdata), .data_rdata(data_rdata),
    .grant_fetch(grant_fetch), .grant_data(grant_data), .fetch_stall(fetch_stall),
    .pc(pc), .dec_instr(dec_instr), .dec_pc(dec_pc), .dec_bubble(dec_bubble),
    .stage_vld(stage_vld), .stall_count(stall_count)
  );

  function automatic logic [31:0] init_word(input int i);
    return (32'(i) * 32'h0101_0103) ^ 32'hA500_0F00;
  endfunction

  function automatic logic exp_collide(input logic f, input logic l);
    return f && l;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state();
    chk("R3/R4 pc", pc, m_pc);
    chk("R3/R4 dec_pc", dec_pc, m_dpc);
    chk("R5 dec_instr", dec_instr, m_vld ? m_instr : 32'h0);
    chk("R5 dec_bubble", {31'b0, dec_bubble}, {31'b0, ~m_vld});
    chk("R6 stage_vld", {28'b0, stage_vld}, {28'b0, m_sv});
    chk("R7 stall_count", stall_count, m_cnt);
  endtask

  // one cycle: drive at negedge, check port side, clock, check state
  task automatic step(input logic f, input logic l, input logic w,
                      input logic [5:0] idx, input logic [31:0] wd);
    logic gf, wr;
    logic [31:0] ea;
    @(negedge clk);
    fetch_req = f; ls_valid = l; ls_write = w;
    ls_addr = {24'b0, idx, 2'b00}; ls_wdata = wd;
    #1;
    gf = f && !l;
    ea = l ? ls_addr : m_pc;
    chk("R1 grant_data", {31'b0, grant_data}, {31'b0, l});
    chk("R1 grant_fetch", {31'b0, grant_fetch}, {31'b0, gf});
    chk("R2 fetch_stall", {31'b0, fetch_stall}, {31'b0, exp_collide(f, l)});
    chk("R1 port_addr", port_addr, ea);
    chk("R1 port_re", {31'b0, port_re}, {31'b0, gf || (l && !w)});
    chk("R1 port_we", {31'b0, port_we}, {31'b0, l && w});
    if (l && !w) chk("R1 data_rdata", data_rdata, mem[idx]);
    if (l && w) chk("R1 port_wdata", port_wdata, wd);
    wr = l && w;
    // next expected state
    m_sv = {m_sv[2:0], gf};
    if (gf) begin
      m_instr = mem[m_pc[7:2]];
      m_dpc = m_pc;
      m_pc = m_pc + 32'd4;
    end
    m_vld = gf;
    if (exp_collide(f, l)) m_cnt = m_cnt + 32'd1;
    @(posedge clk);
    if (wr) mem[idx] = wd;
    #1;
    check_state();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = init_word(i);
    m_pc = 0; m_instr = 0; m_dpc = 0; m_cnt = 0; m_vld = 0; m_sv = 0;
    repeat (3) @(posedge clk);
    #1;
    check_state(); // R8 reset values
    @(negedge clk);
    rst_n = 1'b1;
    // R3 fetch-only run
    repeat (4) step(1, 0, 0, 6'd0, 32'd0);
    // R2 R7 isolated collision (load)
    step(1, 1, 0, 6'd20, 32'd0);
    step(1, 0, 0, 6'd0, 32'd0);
    // R7 three back-to-back collisions, each its own port cycle
    step(1, 1, 1, 6'd30, 32'hDEAD_0001);
    step(1, 1, 0, 6'd30, 32'd0);
    step(1, 1, 1, 6'd31, 32'hDEAD_0002);
    step(1, 0, 0, 6'd0, 32'd0);
    // R5 idle: no fetch, no access -> bubble without count
    step(0, 0, 0, 6'd0, 32'd0);
    step(0, 1, 0, 6'd31, 32'd0);
    step(0, 0, 0, 6'd0, 32'd0);
    // R6 bubbles drain through the tracker
    repeat (4) step(1, 0, 0, 6'd0, 32'd0);
    // random mix, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic rf, rl, rw;
      rf = ($urandom % 4) != 0;
      rl = ($urandom % 3) == 0;
      rw = $urandom % 2;
      step(rf, rl, rw, 6'($urandom), $urandom);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule